// File: doc/BRIEF.md
# Descriptor Load/Store Word Engine

This block executes the two immediate-word descriptor commands of a DMA sequencer. The sequencer hands it one command at a time. Each command carries a direction (load or store), a 3-bit address-space key, a 3-bit size code, a byte address and the 32-bit command-dependent word. The engine turns the size code into a 1-, 2- or 4-byte access and forces the address to that access's natural alignment. It then performs exactly one access to system memory over a request/acknowledge port that has byte enables.

A load returns the memory bytes placed in the top of the command-dependent word, and the bytes below them are kept. A store takes its bytes from the top of that word. When the access completes, the engine pulses `done` with the resulting word. When the key names a space that this unit cannot reach, it pulses `kill` instead and makes no access.

Descriptor write-back and condition tests stay in the sequencer. These commands never branch, so the sequencer always moves on to the following descriptor after `done`.

Top module: `ldst_word_unit`

## Requirements
- R1: When size-code bit 2 is set, the access is 4 bytes, address bits 1:0 are forced to 0 and `mem_be` is 4'b1111, whatever bits 1:0 of the code hold.
- R2: When bit 2 is clear and bit 1 is set, the access is 2 bytes, address bit 0 is forced to 0, and `mem_be` is 4'b0011 when address bit 1 is 0 or 4'b1100 when it is 1. Byte lane k is `mem_wdata`/`mem_rdata` bits 8k+7:8k and serves address offset k.
- R3: When bits 2 and 1 of the code are both clear, the access is 1 byte at the unmodified address, with `mem_be` equal to 1 shifted left by address bits 1:0.
- R4: Keys 0 to 4 are treated as key 6 (system memory). After that mapping, key 5 and key 7 cause a one-cycle `kill` pulse with no memory request and no `done`.
- R5: A 4-byte load returns the full read word as `dep_out`.
- R6: A 2-byte load returns the selected half-word in `dep_out` bits 31:16, with bits 15:0 kept from `req_dep`. A 1-byte load returns the selected byte in bits 31:24, with bits 23:0 kept.
- R7: A store writes `req_dep` to the enabled lanes. For 4 bytes the whole word is written. For 2 bytes, bits 31:16 go to the enabled half, with bits 23:16 in the lower lane of the pair. For 1 byte, bits 31:24 go to the enabled lane.
- R8: A store completes with `done` and returns `dep_out` equal to the `req_dep` it was given.
- R9: `mem_req`, `mem_addr` and `mem_be` hold steady until `mem_ack`. `done` is high for exactly the one cycle after the acknowledged cycle.
- R10: `req_ready` is low from acceptance until the end of the `done` or `kill` cycle. While it is low, `req_valid` is ignored and starts no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Command present |
| req_ready | output | 1 | Engine idle, command taken this cycle if valid |
| req_is_store | input | 1 | 1 = store, 0 = load |
| req_key | input | 3 | Address-space key |
| req_size | input | 3 | Size code |
| req_addr | input | ADDR_W | Byte address |
| req_dep | input | 32 | Command-dependent word |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write |
| mem_addr | output | ADDR_W | Aligned byte address |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle completion pulse |
| kill | output | 1 | One-cycle illegal-key pulse |
| dep_out | output | 32 | Resulting command-dependent word |

## Verification
The bench targets the priority in the size code. Codes 6 and 3 must give 4 and 2 bytes, so a decoder that tests bit 1 first would issue a half-word with the wrong enables. Misaligned addresses check the forced alignment, because an unmasked address shows up directly on `mem_addr`. Loads into the upper half and into a middle byte expose a merge that keeps the wrong low bytes or picks the wrong lane, and stores to both halves catch a swapped byte order inside the pair. Keys 5 and 7 must kill while keys 0, 2 and 4 must succeed, and a request held high while the engine is busy must not start a second access.

// File: rtl/ldsw_pkg.sv
package ldsw_pkg;
   typedef enum logic [1:0] {
      SZ_1 = 2'd0,
      SZ_2 = 2'd1,
      SZ_4 = 2'd2
   } xfer_size_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_MEM  = 2'd1,
      ST_DONE = 2'd2,
      ST_KILL = 2'd3
   } ldsw_state_e;

   localparam int unsigned WORD_W  = 32;
   localparam int unsigned LANES   = WORD_W / 8;
endpackage

// File: rtl/ldsw_size_decode.sv
module ldsw_size_decode
   import ldsw_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned CODE_W = 3
) (
   input  logic [CODE_W-1:0] size_code,
   input  logic [ADDR_W-1:0] addr_in,
   output xfer_size_e        size,
   output logic [ADDR_W-1:0] addr_al,
   output logic [LANES-1:0]  be
);
   if (ADDR_W < 3) begin : g_bad_aw
      $error("ldsw_size_decode: ADDR_W must be at least 3");
   end
   if (CODE_W != 3) begin : g_bad_cw
      $error("ldsw_size_decode: CODE_W must be 3");
   end

   always_comb begin
      size    = SZ_1;
      addr_al = addr_in;
      if (size_code[2]) begin
         size    = SZ_4;
         addr_al = {addr_in[ADDR_W-1:2], 2'b00};
      end else if (size_code[1]) begin
         size    = SZ_2;
         addr_al = {addr_in[ADDR_W-1:1], 1'b0};
      end
   end

   always_comb begin
      unique case (size)
         SZ_4:    be = 4'b1111;
         SZ_2:    be = addr_al[1] ? 4'b1100 : 4'b0011;
         default: be = 4'b0001 << addr_al[1:0];
      endcase
   end
endmodule

// File: rtl/ldsw_key_check.sv
module ldsw_key_check #(
   parameter int unsigned KEY_W         = 3,
   parameter int unsigned FIRST_DEV_KEY = 5,
   parameter int unsigned SYS_KEY       = 6
) (
   input  logic [KEY_W-1:0] key,
   output logic             legal
);
   localparam int unsigned KEY_N = 1 << KEY_W;

   if (SYS_KEY < FIRST_DEV_KEY || SYS_KEY >= KEY_N) begin : g_bad_key
      $error("ldsw_key_check: SYS_KEY out of range");
   end

   logic [KEY_W-1:0] mapped;

   always_comb begin
      mapped = key;
      if (32'(key) < FIRST_DEV_KEY) mapped = KEY_W'(SYS_KEY);
      legal = (32'(mapped) == SYS_KEY);
   end
endmodule

// File: rtl/ldsw_lane_steer.sv
module ldsw_lane_steer
   import ldsw_pkg::*;
#(
   parameter bit ZERO_IDLE_LANES = 1'b1
) (
   input  xfer_size_e        size,
   input  logic [1:0]        lane,
   input  logic [LANES-1:0]  be,
   input  logic [WORD_W-1:0] dep,
   input  logic [WORD_W-1:0] rdata,
   output logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] merged
);
   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [7:0] src;
      always_comb begin
         unique case (size)
            SZ_4:    src = dep[8*k +: 8];
            SZ_2:    src = dep[16 + 8*(k % 2) +: 8];
            default: src = dep[31:24];
         endcase
      end
      if (ZERO_IDLE_LANES) begin : g_zero
         assign wdata[8*k +: 8] = be[k] ? src : 8'h00;
      end else begin : g_repl
         assign wdata[8*k +: 8] = src;
      end
   end

   always_comb begin
      unique case (size)
         SZ_4:    merged = rdata;
         SZ_2:    merged = {(lane[1] ? rdata[31:16] : rdata[15:0]), dep[15:0]};
         default: merged = {rdata[{lane, 3'b000} +: 8], dep[23:0]};
      endcase
   end
endmodule

// File: rtl/ldst_word_unit.sv
module ldst_word_unit
   import ldsw_pkg::*;
#(
   parameter int unsigned ADDR_W          = 32,
   parameter int unsigned KEY_W           = 3,
   parameter int unsigned SIZE_W          = 3,
   parameter int unsigned FIRST_DEV_KEY   = 5,
   parameter int unsigned SYS_KEY         = 6,
   parameter bit          ZERO_IDLE_LANES = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_is_store,
   input  logic [KEY_W-1:0]  req_key,
   input  logic [SIZE_W-1:0] req_size,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [31:0]       req_dep,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [3:0]        mem_be,
   output logic [31:0]       mem_wdata,
   input  logic              mem_ack,
   input  logic [31:0]       mem_rdata,
   output logic              done,
   output logic              kill,
   output logic [31:0]       dep_out
);
   ldsw_state_e       st_q;
   logic              store_q;
   xfer_size_e        size_q;
   logic [ADDR_W-1:0] addr_q;
   logic [LANES-1:0]  be_q;
   logic [31:0]       dep_in_q;
   logic [31:0]       dep_q;

   xfer_size_e        dec_size;
   logic [ADDR_W-1:0] dec_addr;
   logic [LANES-1:0]  dec_be;
   logic              key_ok;
   logic [31:0]       steer_wdata;
   logic [31:0]       steer_merged;

   ldsw_size_decode #(.ADDR_W(ADDR_W), .CODE_W(SIZE_W)) u_dec (
      .size_code (req_size),
      .addr_in   (req_addr),
      .size      (dec_size),
      .addr_al   (dec_addr),
      .be        (dec_be)
   );

   ldsw_key_check #(.KEY_W(KEY_W), .FIRST_DEV_KEY(FIRST_DEV_KEY), .SYS_KEY(SYS_KEY)) u_key (
      .key   (req_key),
      .legal (key_ok)
   );

   ldsw_lane_steer #(.ZERO_IDLE_LANES(ZERO_IDLE_LANES)) u_steer (
      .size   (size_q),
      .lane   (addr_q[1:0]),
      .be     (be_q),
      .dep    (dep_in_q),
      .rdata  (mem_rdata),
      .wdata  (steer_wdata),
      .merged (steer_merged)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         store_q  <= 1'b0;
         size_q   <= SZ_1;
         addr_q   <= '0;
         be_q     <= '0;
         dep_in_q <= '0;
         dep_q    <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (req_valid) begin
               store_q  <= req_is_store;
               size_q   <= dec_size;
               addr_q   <= dec_addr;
               be_q     <= dec_be;
               dep_in_q <= req_dep;
               st_q     <= key_ok ? ST_MEM : ST_KILL;
            end
            ST_MEM: if (mem_ack) begin
               dep_q <= store_q ? dep_in_q : steer_merged;
               st_q  <= ST_DONE;
            end
            ST_DONE: st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (st_q == ST_IDLE);
   assign mem_req   = (st_q == ST_MEM);
   assign mem_we    = store_q;
   assign mem_addr  = addr_q;
   assign mem_be    = be_q;
   assign mem_wdata = steer_wdata;
   assign done      = (st_q == ST_DONE);
   assign kill      = (st_q == ST_KILL);
   assign dep_out   = dep_q;

   AST_ONE_ENDING: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && kill)); // R4
   AST_KILL_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      kill |-> !mem_req && $past(!mem_req)); // R4
   AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_be == 4'hf |-> mem_addr[1:0] == 2'b00); // R1
   AST_HALF_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && $countones(mem_be) == 2 |-> !mem_addr[0] && (mem_be == 4'h3 || mem_be == 4'hc)); // R2
   AST_BYTE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && $countones(mem_be) == 1 |-> mem_be[mem_addr[1:0]]); // R3
   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_be)); // R9
   AST_DONE_FOLLOWS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(mem_req && mem_ack)); // R9
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9
   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req || done || kill) |-> !req_ready); // R10
endmodule

// File: tb/sim_ldst_word_unit.sv
`timescale 1ns/1ps
module sim_ldst_word_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_is_store = 1'b0;
   logic [2:0]  req_key = 3'd6;
   logic [2:0]  req_size = 3'd0;
   logic [31:0] req_addr = '0;
   logic [31:0] req_dep = '0;
   logic        mem_req;
   logic        mem_we;
   logic [31:0] mem_addr;
   logic [3:0]  mem_be;
   logic [31:0] mem_wdata;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        done;
   logic        kill;
   logic [31:0] dep_out;

   always #2 clk = ~clk;

   ldst_word_unit u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_is_store(req_is_store),
      .req_key(req_key), .req_size(req_size), .req_addr(req_addr), .req_dep(req_dep),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .done(done), .kill(kill), .dep_out(dep_out)
   );

   int          n_chk = 0;
   int          n_bad = 0;
   logic [31:0] mem [16];
   int          lat = 0;
   int          txn = 0;
   logic [31:0] last_addr;
   logic [3:0]  last_be;
   logic        last_we;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // memory model, responds on falling edges
   initial begin
      int waited = 0;
      forever begin
         @(negedge clk);
         if (mem_ack) begin
            mem_ack = 1'b0;
            waited  = 0;
         end else if (mem_req) begin
            if (waited >= lat) begin
               txn++;
               last_addr = mem_addr;
               last_be   = mem_be;
               last_we   = mem_we;
               if (mem_we) begin
                  for (int k = 0; k < 4; k++)
                     if (mem_be[k]) mem[mem_addr[5:2]][8*k +: 8] = mem_wdata[8*k +: 8];
               end else begin
                  mem_rdata = mem[mem_addr[5:2]];
               end
               mem_ack = 1'b1;
               waited  = 0;
            end else begin
               waited++;
            end
         end
      end
   end

   // issue one command, wait for done/kill; returns which ended and cycle count
   task automatic run_op(input bit st, input logic [2:0] key, input logic [2:0] sz,
                         input logic [31:0] a, input logic [31:0] d,
                         output bit got_done, output bit got_kill, output int cyc);
      @(negedge clk);
      req_valid = 1'b1; req_is_store = st; req_key = key; req_size = sz;
      req_addr = a; req_dep = d;
      @(negedge clk);
      req_valid = 1'b0;
      got_done = 1'b0; got_kill = 1'b0; cyc = 1;
      while (!done && !kill && cyc < 40) begin
         @(negedge clk);
         cyc++;
      end
      got_done = done; got_kill = kill;
      @(negedge clk);
      chk(!done && !kill, "R9 end pulse one cycle", {30'b0, done, kill}, 32'h0);
   endtask

   task automatic t_reset();
      chk(req_ready === 1'b1, "R10 reset ready", {31'b0, req_ready}, 32'h1);
      chk(done === 1'b0 && kill === 1'b0, "R9 reset no done/kill", {30'b0, done, kill}, 32'h0);
      chk(mem_req === 1'b0, "R9 reset no mem_req", {31'b0, mem_req}, 32'h0);
   endtask

   task automatic t_load(input logic [2:0] sz, input logic [31:0] a, input logic [31:0] d,
                         input logic [31:0] exp_addr, input logic [3:0] exp_be,
                         input logic [31:0] exp_dep, input string tag);
      bit gd, gk; int c; int t0 = txn;
      run_op(1'b0, 3'd6, sz, a, d, gd, gk, c);
      chk(gd && !gk, {tag, " done"}, {30'b0, gd, gk}, 32'h2);
      chk(txn == t0 + 1, {tag, " one access"}, txn - t0, 1);
      chk(last_addr == exp_addr, {tag, " addr"}, last_addr, exp_addr);
      chk(last_be == exp_be, {tag, " be"}, {28'b0, last_be}, {28'b0, exp_be});
      chk(dep_out == exp_dep, {tag, " dep_out"}, dep_out, exp_dep);
   endtask

   task automatic t_store(input logic [2:0] sz, input logic [31:0] a, input logic [31:0] d,
                          input logic [31:0] pre, input logic [31:0] post, input string tag);
      bit gd, gk; int c;
      mem[a[5:2]] = pre;
      run_op(1'b1, 3'd6, sz, a, d, gd, gk, c);
      chk(gd && last_we, {tag, " write done"}, {30'b0, gd, last_we}, 32'h3);
      chk(mem[a[5:2]] == post, {tag, " memory"}, mem[a[5:2]], post);
      chk(dep_out == d, "R8 store dep_out unchanged", dep_out, d);
   endtask

   task automatic t_keys();
      bit gd, gk; int c; int t0;
      t0 = txn;
      run_op(1'b0, 3'd5, 3'd4, 32'h4, 32'h0, gd, gk, c);
      chk(gk && !gd && txn == t0, "R4 key5 kill no access", {30'b0, gd, gk}, 32'h1);
      run_op(1'b1, 3'd7, 3'd4, 32'h4, 32'h0, gd, gk, c);
      chk(gk && !gd && txn == t0, "R4 key7 kill no access", {30'b0, gd, gk}, 32'h1);
      for (int k = 0; k < 5; k += 2) begin
         run_op(1'b0, 3'(k), 3'd4, 32'h4, 32'h0, gd, gk, c);
         chk(gd && !gk, "R4 low key maps to system", {29'b0, 3'(k)}, 32'h6);
      end
      chk(txn == t0 + 3, "R4 access count", txn - t0, 3);
   endtask

   task automatic t_timing();
      bit gd, gk; int c;
      for (int l = 0; l < 4; l += 3) begin
         lat = l;
         run_op(1'b0, 3'd6, 3'd4, 32'h0, 32'h0, gd, gk, c);
         chk(gd && c == 2 + l, "R9 done cycle after ack", c, 2 + l);
      end
      lat = 0;
   endtask

   task automatic t_busy();
      int t0 = txn; int c = 0;
      lat = 3;
      mem[6] = 32'h0;
      @(negedge clk);
      req_valid = 1'b1; req_is_store = 1'b0; req_key = 3'd6; req_size = 3'd4;
      req_addr = 32'h14; req_dep = 32'h0;
      @(negedge clk);
      chk(req_ready === 1'b0, "R10 not ready when busy", {31'b0, req_ready}, 32'h0);
      req_is_store = 1'b1; req_addr = 32'h18; req_dep = 32'hDEADBEEF;
      while (!done && c < 40) begin @(negedge clk); c++; end
      req_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk(txn == t0 + 1, "R10 busy request ignored", txn - t0, 1);
      chk(mem[6] == 32'h0, "R10 no write from ignored request", mem[6], 32'h0);
      lat = 0;
   endtask

   initial begin
      bit finished = 0;
      fork
         begin
            for (int i = 0; i < 16; i++) mem[i] = 32'h0;
            repeat (3) @(negedge clk);
            t_reset();
            rst_n = 1'b1;
            mem[1] = 32'hA1B2C3D4; mem[2] = 32'h11223344; mem[3] = 32'h55667788;
            t_load(3'd4, 32'h07, 32'h0, 32'h04, 4'hf, 32'hA1B2C3D4, "R1 R5 load4 misaligned");
            t_load(3'd6, 32'h05, 32'h0, 32'h04, 4'hf, 32'hA1B2C3D4, "R1 code6 priority");
            t_load(3'd2, 32'h0B, 32'hCAFEBEEF, 32'h0A, 4'hc, 32'h1122BEEF, "R2 R6 load2 upper");
            t_load(3'd3, 32'h09, 32'hCAFEBEEF, 32'h08, 4'h3, 32'h3344BEEF, "R2 R6 code3 lower");
            t_load(3'd1, 32'h0D, 32'h01234567, 32'h0D, 4'h2, 32'h77234567, "R3 R6 load1 lane1");
            t_load(3'd0, 32'h0F, 32'h01234567, 32'h0F, 4'h8, 32'h55234567, "R3 R6 load1 lane3");
            t_store(3'd4, 32'h22, 32'h89ABCDEF, 32'h0, 32'h89ABCDEF, "R7 store4");
            t_store(3'd2, 32'h11, 32'hABCD1234, 32'h99999999, 32'h9999ABCD, "R7 store2 lower");
            t_store(3'd2, 32'h12, 32'hABCD1234, 32'h99999999, 32'hABCD9999, "R7 store2 upper");
            t_store(3'd1, 32'h13, 32'h5A000000, 32'h11111111, 32'h5A111111, "R7 store1 lane3");
            t_keys();
            t_timing();
            t_busy();
            finished = 1;
         end
         begin
            repeat (20000) @(posedge clk);
            if (!finished) begin
               n_chk++; n_bad++;
               $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            end
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule